// File: doc/BRIEF.md
# Packed 9-bit Symbol Error Corrector

This block repairs a 512-byte sector sitting in a byte-wide buffer memory. It takes the list of symbol errors that a Reed-Solomon decoder has already located and applies them. The sector is viewed as a continuous little-endian bit stream cut into 9-bit symbols. Each reported error carries a symbol number and a 9-bit flip mask. The block turns each symbol number into the pair of neighbouring bytes that hold the symbol. It then reads both bytes, XORs the mask in at the right bit offset and writes both bytes back. Computing syndromes and locating errors happen elsewhere.

A controller fills the error slots, sets the count and the uncorrectable flag, and pulses `start`. The corrector then owns the buffer port until it pulses `done`. `fail` comes with `done` when the decoder flagged the sector as beyond repair. Each sector is guarded by 9 parity bytes. The parity for sector k sits in the spare area at offset 6 + 9*k. Moving those bytes is the controller's job.

Top module: `rs9_corrector`

## Requirements
- R1: Symbol number n (n >= 1) occupies packed bits 9*(n-1) to 9*(n-1)+8, where packed bit p is bit p%8 of byte p/8. Bit b of a slot's mask is XORed into packed bit 9*(n-1)+b, and every other buffer bit keeps its value.
- R2: An applied correction whose symbol lies wholly inside the buffer makes exactly two writes. The first goes to byte floor(9*(n-1)/8) and the second to the byte after it. Both are preceded by reads of the same two bytes, and the read data returns one cycle after the address.
- R3: Symbol 456 straddles the end of the buffer. Only byte 511 is read and written, in a single write, and the mask bits that fall past bit 4095 are dropped.
- R4: Symbol number 0 and symbol numbers of 457 or more are skipped with no memory write.
- R5: Slot s is err_idx[10*s +: 10] and err_mask[9*s +: 9]. With a count c from 1 to 4, slots c-1 down to 0 are applied in that order. Later corrections see the bytes written by earlier ones.
- R6: With `uncorr` high at start, nothing is written and `done` and `fail` pulse together in the cycle after the start edge.
- R7: A count of 0, or a count from 5 to 7, causes no writes. `done` pulses in the cycle after the start edge and `fail` stays low.
- R8: `done` is a single-cycle pulse issued once per job, in the cycle after the last write. `fail` is never high without `done`.
- R9: Synchronous active-low reset clears `done`, `fail` and `mem_we`, and it abandons any job in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a job; sampled only while idle |
| err_cnt | input | 3 | Number of valid error slots |
| err_idx | input | 40 | Four 10-bit symbol numbers, slot 0 in the low bits |
| err_mask | input | 36 | Four 9-bit flip masks, slot 0 in the low bits |
| uncorr | input | 1 | Decoder reports the sector uncorrectable |
| mem_addr | output | 9 | Buffer byte address |
| mem_rdata | input | 8 | Buffer read data, one cycle after address |
| mem_wdata | output | 8 | Buffer write data |
| mem_we | output | 1 | Buffer write enable |
| done | output | 1 | Job finished (one-cycle pulse) |
| fail | output | 1 | Job rejected as uncorrectable, with done |

## Verification
The bench checks symbols whose offset is a multiple of eight, where the low byte moves back by one and the shift becomes 7. A design that misses that step flips bits in the wrong byte. It checks symbol 456 at the end of the buffer, where a design without clipping would write past byte 511, and the skipped symbols 0 and 457, where a broken skip would corrupt byte 0 or wrap the address. Jobs with two errors that share a byte expose a design that reads all bytes before writing any, because it loses the first fix. The first write address shows whether the slots run from the top down. Out-of-range counts and the uncorrectable flag must leave the buffer untouched and finish in one cycle.

// File: rtl/rs9_pkg.sv
// Shared types for the packed 9-bit symbol corrector.
// Assumes: symbols are always 9 bits wide; buffer bytes are 8 bits.
package rs9_pkg;
    localparam int unsigned SYM_W  = 9;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SEL,
        S_RDLO,
        S_RDHI,
        S_CAP,
        S_WRLO,
        S_WRHI
    } corr_state_e;
endpackage

// File: rtl/rs9_locate.sv
// Maps a symbol number onto its byte pair and bit shift.
// Computes t = 9*n, byte i = t/8, offset j = t%8, then moves back one bit
// (i-1 with shift 7 when j is 0). The pair is bytes i-1 (low) and i (high).
// Assumes: purely combinational; the caller registers nothing here.
module rs9_locate #(
    parameter int unsigned IDX_W        = 10,
    parameter int unsigned ADDR_W       = 9,
    parameter int unsigned SECTOR_BYTES = 512
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] lo_addr,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [2:0]        shift,
    output logic              at_end,
    output logic              skip
);
    localparam int unsigned T_W = IDX_W + 4;
    localparam int unsigned I_W = T_W - 3;
    localparam logic [I_W-1:0] SECT_I = I_W'(SECTOR_BYTES);

    logic [T_W-1:0] bit_pos;
    logic [I_W-1:0] byte_i;
    logic [I_W-1:0] hi_i;

    // Derive the byte pair, the shift and the range flags from the symbol number
    always_comb begin
        bit_pos = T_W'(idx) * T_W'(9);
        byte_i  = bit_pos[T_W-1:3];
        if (bit_pos[2:0] == 3'd0) begin
            hi_i  = byte_i - I_W'(1);
            shift = 3'd7;
        end else begin
            hi_i  = byte_i;
            shift = bit_pos[2:0] - 3'd1;
        end
        lo_addr = ADDR_W'(hi_i - I_W'(1));
        hi_addr = ADDR_W'(hi_i);
        at_end  = (hi_i == SECT_I);
        skip    = (idx == '0) || (hi_i > SECT_I);
    end
endmodule

// File: rtl/rs9_merge.sv
// XORs a 9-bit mask into a 16-bit byte pair at a given shift.
// Assumes: shift <= 7, so the shifted mask always fits in the pair.
module rs9_merge
    import rs9_pkg::*;
(
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [BYTE_W-1:0] hi_in,
    input  logic [2:0]        shift,
    input  logic [SYM_W-1:0]  mask,
    output logic [BYTE_W-1:0] lo_out,
    output logic [BYTE_W-1:0] hi_out
);
    logic [2*BYTE_W-1:0] flip;
    logic [2*BYTE_W-1:0] word;

    // Align the mask and apply it to the joined pair
    always_comb begin
        flip   = (2*BYTE_W)'(mask) << shift;
        word   = {hi_in, lo_in} ^ flip;
        lo_out = word[BYTE_W-1:0];
        hi_out = word[2*BYTE_W-1:BYTE_W];
    end
endmodule

// File: rtl/rs9_seq.sv
// Walks the error slots from the highest down to slot 0 and runs a
// read/read/capture/write/write cycle on the buffer for each symbol.
// Assumes: single-port buffer with one-cycle read latency; the slot
// contents are held stable by the caller while a job runs.
module rs9_seq
    import rs9_pkg::*;
#(
    parameter int unsigned MAX_ERR = 4,
    parameter int unsigned ADDR_W  = 9,
    parameter int unsigned CNT_W   = 3,
    parameter int unsigned SLOT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  err_cnt,
    input  logic              uncorr,
    input  logic              skip,
    input  logic              at_end,
    input  logic [ADDR_W-1:0] lo_addr,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [BYTE_W-1:0] new_lo,
    input  logic [BYTE_W-1:0] new_hi,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              accept,
    output logic [SLOT_W-1:0] slot,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              done,
    output logic              fail
);
    corr_state_e state;
    logic        cnt_ok;
    logic        last_slot;

    assign cnt_ok    = (err_cnt != '0) && (err_cnt <= CNT_W'(MAX_ERR));
    assign last_slot = (slot == '0);
    assign accept    = start && (state == S_IDLE);

    // Job control, slot countdown and capture of the two read bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            slot  <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            done <= 1'b0;
            fail <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (uncorr) begin
                            done <= 1'b1;
                            fail <= 1'b1;
                        end else if (cnt_ok) begin
                            slot  <= SLOT_W'(err_cnt - CNT_W'(1));
                            state <= S_SEL;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                S_SEL: begin
                    if (skip) begin
                        if (last_slot) begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end else begin
                            slot <= slot - SLOT_W'(1);
                        end
                    end else begin
                        state <= S_RDLO;
                    end
                end
                S_RDLO: state <= S_RDHI;
                S_RDHI: begin
                    lo_q  <= mem_rdata;
                    hi_q  <= '0;
                    state <= at_end ? S_WRLO : S_CAP;
                end
                S_CAP: begin
                    hi_q  <= mem_rdata;
                    state <= S_WRLO;
                end
                S_WRLO, S_WRHI: begin
                    if (state == S_WRLO && !at_end) begin
                        state <= S_WRHI;
                    end else if (last_slot) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        slot  <= slot - SLOT_W'(1);
                        state <= S_SEL;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Buffer port: the high address on the second read and the second write
    always_comb begin
        mem_we    = (state == S_WRLO) || (state == S_WRHI);
        mem_wdata = (state == S_WRHI) ? new_hi : new_lo;
        if ((state == S_RDHI && !at_end) || state == S_WRHI)
            mem_addr = hi_addr;
        else
            mem_addr = lo_addr;
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);
    a_r4_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SEL && skip) |=> !mem_we);
    a_r3_end_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRLO && at_end) |=> !mem_we);
    a_r2_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WRLO && !at_end) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1)));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !mem_we);
endmodule

// File: rtl/rs9_corrector.sv
// Top of the packed 9-bit symbol corrector. Holds the error slots for the
// running job and wires the locator, the merger and the sequencer together.
// Assumes: the buffer answers reads one cycle after the address.
module rs9_corrector
    import rs9_pkg::*;
#(
    parameter int unsigned SECTOR_BYTES = 512,
    parameter int unsigned MAX_ERR      = 4,
    parameter int unsigned IDX_W        = 10,
    localparam int unsigned ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int unsigned CNT_W       = $clog2(MAX_ERR + 1),
    localparam int unsigned SLOT_W      = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         err_cnt,
    input  logic [MAX_ERR*IDX_W-1:0] err_idx,
    input  logic [MAX_ERR*SYM_W-1:0] err_mask,
    input  logic                     uncorr,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic [BYTE_W-1:0]        mem_rdata,
    output logic [BYTE_W-1:0]        mem_wdata,
    output logic                     mem_we,
    output logic                     done,
    output logic                     fail
);
    logic [IDX_W-1:0]  idx_q  [MAX_ERR];
    logic [SYM_W-1:0]  mask_q [MAX_ERR];
    logic              accept;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  cur_idx;
    logic [SYM_W-1:0]  cur_mask;
    logic [ADDR_W-1:0] lo_addr, hi_addr;
    logic [2:0]        shift;
    logic              at_end, skip;
    logic [BYTE_W-1:0] lo_q, hi_q, new_lo, new_hi;

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_slot
        // Hold this slot's symbol number and mask for the whole job
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[g]  <= '0;
                mask_q[g] <= '0;
            end else if (accept) begin
                idx_q[g]  <= err_idx[g*IDX_W +: IDX_W];
                mask_q[g] <= err_mask[g*SYM_W +: SYM_W];
            end
        end
    end

    assign cur_idx  = idx_q[slot];
    assign cur_mask = mask_q[slot];

    rs9_locate #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_locate (
        .idx(cur_idx), .lo_addr(lo_addr), .hi_addr(hi_addr),
        .shift(shift), .at_end(at_end), .skip(skip)
    );

    rs9_merge u_merge (
        .lo_in(lo_q), .hi_in(hi_q), .shift(shift), .mask(cur_mask),
        .lo_out(new_lo), .hi_out(new_hi)
    );

    rs9_seq #(
        .MAX_ERR(MAX_ERR), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
        .uncorr(uncorr), .skip(skip), .at_end(at_end),
        .lo_addr(lo_addr), .hi_addr(hi_addr),
        .new_lo(new_lo), .new_hi(new_hi), .mem_rdata(mem_rdata),
        .accept(accept), .slot(slot), .lo_q(lo_q), .hi_q(hi_q),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .done(done), .fail(fail)
    );

    a_r6_quiet_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && uncorr) |=> (!mem_we && done && fail));
endmodule

// File: tb/rs9_corrector_tb.sv
`timescale 1ns/1ps
module rs9_corrector_tb;
    localparam int NV = 11;
    localparam int V_CNT [NV] = '{1, 4, 2, 1, 1, 2, 2, 0, 5, 3, 4};
    localparam int V_UNC [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
    localparam int V_IDX [NV][4] = '{
        '{5, 0, 0, 0}, '{10, 20, 30, 40}, '{7, 8, 0, 0}, '{16, 0, 0, 0},
        '{456, 0, 0, 0}, '{457, 3, 0, 0}, '{11, 12, 0, 0}, '{9, 0, 0, 0},
        '{1, 2, 3, 4}, '{0, 455, 1, 0}, '{100, 100, 200, 1}};
    localparam int V_MSK [NV][4] = '{
        '{'h1FF, 0, 0, 0}, '{'h001, 'h100, 'h0AA, 'h155}, '{'h1FF, 'h1FF, 0, 0},
        '{'h0F0, 0, 0, 0}, '{'h1FF, 0, 0, 0}, '{'h1FF, 'h003, 0, 0},
        '{'h1FF, 'h1FF, 0, 0}, '{'h1FF, 0, 0, 0}, '{'h1FF, 'h1FF, 'h1FF, 'h1FF},
        '{'h1FF, 'h1FF, 'h1FF, 0}, '{'h0F0, 'h00F, 'h111, 'h080}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  err_cnt = '0;
    logic [39:0] err_idx = '0;
    logic [35:0] err_mask = '0;
    logic        uncorr = 1'b0;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        done, fail;

    logic [7:0]  mem [512];
    logic [7:0]  exp_mem [512];
    logic        load = 1'b0;
    logic        clr = 1'b0;
    logic [7:0]  seed = '0;
    int          wr_cnt, first_wr, done_cnt, fail_cnt;
    int          n_run = 0, n_fail = 0;
    bit          timed_out = 0;

    always #4 clk = ~clk;

    rs9_corrector u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
        .err_idx(err_idx), .err_mask(err_mask), .uncorr(uncorr),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .done(done), .fail(fail)
    );

    // Buffer model with one-cycle read latency plus write and pulse monitors
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (load) begin
            for (int a = 0; a < 512; a++) mem[a] <= 8'(a * 37) + seed;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        if (clr) begin
            wr_cnt <= 0; done_cnt <= 0; fail_cnt <= 0; first_wr <= -1;
        end else begin
            if (mem_we) begin
                if (wr_cnt == 0) first_wr <= int'(mem_addr);
                wr_cnt <= wr_cnt + 1;
            end
            if (done) done_cnt <= done_cnt + 1;
            if (fail) fail_cnt <= fail_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic prep(input logic [7:0] s);
        @(negedge clk); seed = s; load = 1'b1; clr = 1'b1;
        @(negedge clk); load = 1'b0; clr = 1'b0;
    endtask

    task automatic drive(input int v);
        err_cnt = 3'(V_CNT[v]);
        uncorr  = V_UNC[v][0];
        for (int s = 0; s < 4; s++) begin
            err_idx[s*10 +: 10] = 10'(V_IDX[v][s]);
            err_mask[s*9 +: 9]  = 9'(V_MSK[v][s]);
        end
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Expected buffer from the packed-bit view of R1, R3, R4 and R5
    task automatic model(input int v, output int wr, output int first);
        wr = 0; first = -1;
        for (int a = 0; a < 512; a++) exp_mem[a] = mem[a];
        if (V_UNC[v] == 0 && V_CNT[v] >= 1 && V_CNT[v] <= 4) begin
            for (int s = V_CNT[v] - 1; s >= 0; s--) begin
                int n;
                n = V_IDX[v][s];
                if (n == 0 || n >= 457) continue;
                wr += (n == 456) ? 1 : 2;
                if (first < 0) first = (9 * (n - 1)) / 8;
                for (int b = 0; b < 9; b++) begin
                    int p;
                    p = 9 * (n - 1) + b;
                    if (V_MSK[v][s][b] && p < 4096) exp_mem[p / 8][p % 8] ^= 1'b1;
                end
            end
        end
    endtask

    task automatic run_vec(input int v);
        int wr_e, first_e, bad, wait_n;
        prep(8'(v * 13 + 5));
        model(v, wr_e, first_e);
        drive(v);
        wait_n = 0;
        while (done_cnt == 0 && wait_n < 200) begin @(negedge clk); wait_n++; end
        repeat (3) @(negedge clk);
        chk(done_cnt == 1, $sformatf("R8 vec%0d done pulses", v), done_cnt, 1);
        chk(fail_cnt == V_UNC[v], $sformatf("R6 vec%0d fail pulses", v), fail_cnt, V_UNC[v]);
        chk(wr_cnt == wr_e, $sformatf("R2 R3 R4 R7 vec%0d writes", v), wr_cnt, wr_e);
        if (wr_e > 0)
            chk(first_wr == first_e, $sformatf("R5 vec%0d first write addr", v), first_wr, first_e);
        bad = 0;
        for (int a = 0; a < 512; a++) if (mem[a] !== exp_mem[a]) bad++;
        chk(bad == 0, $sformatf("R1 vec%0d mismatching bytes", v), bad, 0);
    endtask

    task automatic run_all();
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!done && !fail && !mem_we, "R9 reset outputs", int'({done, fail, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R7: empty job finishes in the cycle after the start edge
        prep(8'h21);
        drive(7);
        chk(done && !fail, "R7 done one cycle after start", int'({done, fail}), 2);
        @(negedge clk);
        chk(!done, "R8 done drops after one cycle", int'(done), 0);

        // R6: uncorrectable job timing
        prep(8'h22);
        drive(6);
        chk(done && fail, "R6 done and fail one cycle after start", int'({done, fail}), 3);

        // R9: reset during a running job
        prep(8'h23);
        drive(1);
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!mem_we && !done, "R9 reset abandons job", int'({mem_we, done}), 0);
        repeat (6) @(negedge clk);
        chk(!mem_we && !done, "R9 stays quiet in reset", int'({mem_we, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_vec(0);
    endtask

    initial begin
        fork
            run_all();
            begin #800000; timed_out = 1; end
        join_any
        disable fork;
        if (timed_out) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule